// File: doc/BRIEF.md
# Triggered Transfer Task Sequencer

This block is one automatic-transfer slot that sits beside a serial bus master. Software gives it a buffer base address, a byte count and a direction. It is then armed, and it launches on a software trigger edge or on an external trigger pulse. While it runs, each byte that the bus engine completes moves the buffer address on by one and lowers a remaining-count register by one. In receive direction the byte is written to memory. In transmit direction the byte is read from memory and offered to the engine.

The slot signals separately when the first half of the buffer is full and when the whole buffer is full. In reload mode it then rewinds to the base address and waits for the next trigger, so software can use the buffer as a ping-pong pair: the first half is ready at the half event, and the second half, starting at base + count/2, is ready at the complete event. A NACK or bus error from the engine gives a separate error event.

The byte channel toward the engine uses valid/ready. The engine raises `eng_valid` when it has finished a byte. It must hold `eng_valid` and `eng_rdata` steady until it sees `eng_ready`, and the byte counts as done in the cycle where both are high. `eng_ready` is low whenever the slot is not running. It is also low in any cycle that carries a fault, a software stop, or a write to the DMA control word, so none of those cycles can also complete a byte. Memory is a plain strobe port with a combinational read.

Top module: `task_dma_seq`

## Requirements
- R1: After reset every register reads 0, `busy`, `eng_ready` and all three event outputs are 0.
- R2: Register map (word index in `reg_addr[5:2]`; unmapped words read 0):
  - 0x00 task control: bit 31 is the software start, bit 0 is the direction (1 = receive into memory, 0 = transmit from memory).
  - 0x04 DMA control: bit 0 is arm, bit 1 is reload.
  - 0x08 base address.
  - 0x0C byte count.
  - 0x10 remaining count. It is read-only, and a write to it changes nothing.
- R3: Writing DMA control with bit 0 set does three things:
  - It arms the slot only if the count is nonzero. When the count is zero, bit 0 reads back 0 and triggers are ignored.
  - It loads the current address with the base.
  - It loads the remaining count with the count.
  Writing bit 0 clear disarms the slot and stops any run.
- R4: Software start triggers only when task-control bit 31 goes from 0 to 1 on an armed, idle slot. Writing 1 while the bit is already 1 does not start a run. Clearing the bit stops a run that software started.
- R5: A one-cycle `ext_trig` pulse starts an armed, idle slot. A pulse while the slot runs is ignored: the address and the remaining count do not move.
- R6: While running, each byte completes on a handshake with `eng_valid` and `eng_ready` both high. That byte uses address base+k for the k-th byte:
  - In receive direction, `mem_wr` pulses in that cycle with `mem_wdata = eng_rdata`.
  - In transmit direction, `mem_rd` is high and `eng_tdata` carries `mem_rdata` for the current address.
- R7: The remaining count reads back the count minus the bytes transferred since the slot was armed or reloaded.
- R8: `evt_half` pulses for one cycle, in the cycle after the byte that brings the transferred total to count/2 (integer division). It never pulses when count is 1.
- R9: `evt_done` pulses for one cycle, in the cycle after the byte that brings the transferred total to count. Without reload the slot then goes idle and disarmed, and DMA-control bit 0 reads 0.
- R10: With reload set, completion rewinds the address to the base and the remaining count to the count. The slot stays armed and idle until the next trigger, and the next byte lands at the base address.
- R11: An `eng_fault` pulse during a run has three effects:
  - `eng_ready` is held low in that cycle.
  - `evt_err` pulses in the next cycle.
  - The slot stops, and it keeps its address and remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_trig | input | 1 | External trigger pulse |
| eng_valid | input | 1 | Engine finished a byte |
| eng_ready | output | 1 | Slot accepts the finished byte |
| eng_rdata | input | 8 | Received byte from the engine |
| eng_tdata | output | 8 | Byte to transmit |
| eng_fault | input | 1 | NACK or bus error pulse |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| evt_half | output | 1 | First half of the buffer done |
| evt_done | output | 1 | Whole buffer done |
| evt_err | output | 1 | Fault during a run |
| busy | output | 1 | Slot is running |

## Verification
The hardest state to reach is the reload boundary in the middle of a stream. The slot has to finish a full buffer, rewind itself, stay armed without running, and then place the first byte of the next trigger back at the base address. The stimulus builds this up in order. It arms a six-byte buffer with reload, starts it with an external pulse, and fires a second pulse mid-run to show that the pulse is ignored. It finishes the buffer, then re-triggers, and lets the write scoreboard confirm that the address wrapped. The fault case is reached from inside that second run, so the error stop is seen after real progress has been made.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int REG_IDX_W = 4;
  typedef enum logic [REG_IDX_W-1:0] {
    IDX_TCTL = 4'd0,
    IDX_DCTL = 4'd1,
    IDX_BASE = 4'd2,
    IDX_CNT  = 4'd3,
    IDX_REM  = 4'd4
  } reg_idx_e;
  localparam int SOFT_BIT   = 31;
  localparam int DIR_BIT    = 0;
  localparam int ARM_BIT    = 0;
  localparam int RELOAD_BIT = 1;
endpackage

// File: rtl/tslot_regs.sv
module tslot_regs
  import tslot_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [31:0]          wdata,
  input  logic                 armed,
  input  logic [CW-1:0]        remain,
  output logic [31:0]          rdata,
  output logic                 dir_rx,
  output logic                 reload,
  output logic [AW-1:0]        base,
  output logic [CW-1:0]        cnt,
  output logic                 arm_wr,
  output logic                 disarm_wr,
  output logic                 soft_rise,
  output logic                 soft_fall
);
  logic soft_q;
  logic unused_bits;
  assign unused_bits = ^wdata;

  logic wr_tctl, wr_dctl;
  assign wr_tctl   = wr && (idx == IDX_TCTL);
  assign wr_dctl   = wr && (idx == IDX_DCTL);
  assign arm_wr    = wr_dctl && wdata[ARM_BIT];
  assign disarm_wr = wr_dctl && !wdata[ARM_BIT];
  assign soft_rise = wr_tctl && wdata[SOFT_BIT] && !soft_q;
  assign soft_fall = wr_tctl && !wdata[SOFT_BIT] && soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      dir_rx <= 1'b0;
      reload <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (wr) begin
      case (idx)
        IDX_TCTL: begin
          soft_q <= wdata[SOFT_BIT];
          dir_rx <= wdata[DIR_BIT];
        end
        IDX_DCTL: reload <= wdata[RELOAD_BIT];
        IDX_BASE: base   <= wdata[AW-1:0];
        IDX_CNT:  cnt    <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_TCTL: begin
        rdata[SOFT_BIT] = soft_q;
        rdata[DIR_BIT]  = dir_rx;
      end
      IDX_DCTL: begin
        rdata[ARM_BIT]    = armed;
        rdata[RELOAD_BIT] = reload;
      end
      IDX_BASE: rdata[AW-1:0] = base;
      IDX_CNT:  rdata[CW-1:0] = cnt;
      IDX_REM:  rdata[CW-1:0] = remain;
      default: ;
    endcase
  end
endmodule

// File: rtl/tslot_trig.sv
module tslot_trig (
  input  logic ext_trig,
  input  logic soft_rise,
  input  logic soft_fall,
  input  logic armed,
  input  logic running,
  input  logic running_soft,
  output logic start,
  output logic start_soft,
  output logic stop
);
  logic idle_armed;
  assign idle_armed = armed && !running;
  assign start      = idle_armed && (ext_trig || soft_rise);
  assign start_soft = idle_armed && soft_rise;
  assign stop       = running && running_soft && soft_fall;
endmodule

// File: rtl/tslot_walker.sv
module tslot_walker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_wr,
  input  logic          disarm_wr,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          reload,
  input  logic          start,
  input  logic          start_soft,
  input  logic          stop,
  input  logic          xfer,
  input  logic          fault,
  output logic          armed,
  output logic          running,
  output logic          running_soft,
  output logic [AW-1:0] cur,
  output logic [CW-1:0] remain,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err
);
  localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};

  logic [CW-1:0] rem_nx, half_mark;
  assign rem_nx    = remain - ONE_C;
  assign half_mark = cnt - (cnt >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      running      <= 1'b0;
      running_soft <= 1'b0;
      cur          <= '0;
      remain       <= '0;
      evt_half     <= 1'b0;
      evt_done     <= 1'b0;
      evt_err      <= 1'b0;
    end else begin
      evt_half <= 1'b0;
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
      if (disarm_wr) begin
        armed   <= 1'b0;
        running <= 1'b0;
      end else if (arm_wr) begin
        armed   <= (cnt != '0);
        running <= 1'b0;
        cur     <= base;
        remain  <= cnt;
      end else if (running && fault) begin
        running <= 1'b0;
        evt_err <= 1'b1;
      end else if (stop) begin
        running <= 1'b0;
      end else if (xfer) begin
        cur    <= cur + ONE_A;
        remain <= rem_nx;
        if (rem_nx == half_mark) evt_half <= 1'b1;
        if (rem_nx == '0) begin
          evt_done <= 1'b1;
          running  <= 1'b0;
          if (reload) begin
            cur    <= base;
            remain <= cnt;
          end else begin
            armed <= 1'b0;
          end
        end
      end else if (start) begin
        running      <= 1'b1;
        running_soft <= start_soft;
      end
    end
  end
endmodule

// File: rtl/task_dma_seq.sv
module task_dma_seq
  import tslot_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ext_trig,
  input  logic          eng_valid,
  output logic          eng_ready,
  input  logic [7:0]    eng_rdata,
  output logic [7:0]    eng_tdata,
  input  logic          eng_fault,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err,
  output logic          busy
);
  logic unused_addr;
  assign unused_addr = ^reg_addr[1:0];

  logic          dir_rx, reload, arm_wr, disarm_wr, soft_rise, soft_fall;
  logic          armed, running, running_soft, start, start_soft, stop, xfer;
  logic [AW-1:0] base, cur;
  logic [CW-1:0] cnt, remain;

  tslot_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_addr[5:2]),
    .wdata(reg_wdata), .armed(armed), .remain(remain), .rdata(reg_rdata),
    .dir_rx(dir_rx), .reload(reload), .base(base), .cnt(cnt),
    .arm_wr(arm_wr), .disarm_wr(disarm_wr),
    .soft_rise(soft_rise), .soft_fall(soft_fall)
  );

  tslot_trig u_trig (
    .ext_trig(ext_trig), .soft_rise(soft_rise), .soft_fall(soft_fall),
    .armed(armed), .running(running), .running_soft(running_soft),
    .start(start), .start_soft(start_soft), .stop(stop)
  );

  assign eng_ready = running && !(eng_fault || stop || arm_wr || disarm_wr);
  assign xfer      = eng_valid && eng_ready;

  tslot_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .disarm_wr(disarm_wr),
    .base(base), .cnt(cnt), .reload(reload), .start(start),
    .start_soft(start_soft), .stop(stop), .xfer(xfer), .fault(eng_fault),
    .armed(armed), .running(running), .running_soft(running_soft),
    .cur(cur), .remain(remain), .evt_half(evt_half), .evt_done(evt_done),
    .evt_err(evt_err)
  );

  assign mem_addr  = cur;
  assign mem_wr    = xfer && dir_rx;
  assign mem_wdata = eng_rdata;
  assign mem_rd    = running && !dir_rx;
  assign eng_tdata = mem_rdata;
  assign busy      = running;
endmodule

// File: rtl/tslot_chk.sv
module tslot_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          ext_trig,
  input logic          eng_valid,
  input logic          eng_ready,
  input logic          eng_fault,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          evt_half,
  input logic          evt_done,
  input logic          evt_err,
  input logic          busy
);
  assert_wr_needs_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (eng_valid && eng_ready));

  assert_addr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && eng_ready && !reg_wr) |=>
      (evt_done || mem_addr == AW'($past(mem_addr) + 1'b1)));

  assert_done_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(eng_valid && eng_ready));

  assert_half_not_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_half && evt_done));

  assert_err_after_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> ($past(eng_fault && busy) && !busy));

  assert_start_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ext_trig || reg_wr));
endmodule

bind task_dma_seq tslot_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ext_trig(ext_trig),
  .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_fault(eng_fault),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .evt_half(evt_half),
  .evt_done(evt_done), .evt_err(evt_err), .busy(busy)
);

// File: tb/sim_task_dma_seq.sv
`timescale 1ns/1ps
module sim_task_dma_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ext_trig = 1'b0, eng_valid = 1'b0, eng_ready, eng_fault = 1'b0;
  logic [7:0] eng_rdata = '0, eng_tdata, mem_wdata, mem_rdata;
  logic mem_wr, mem_rd, evt_half, evt_done, evt_err, busy;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0;
  logic [23:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  task_dma_seq #(.AW(AW), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_rdata(eng_rdata),
    .eng_tdata(eng_tdata), .eng_fault(eng_fault), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .evt_half(evt_half), .evt_done(evt_done),
    .evt_err(evt_err), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every memory write with the queue head
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_wr) begin
      if (sb_q.size() == 0) chk("R6 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      else chk("R6 write", {8'h0, mem_addr, mem_wdata}, {8'h0, sb_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic rx_byte(input logic [15:0] a, input logic [7:0] d,
                         output logic h, output logic dn);
    @(negedge clk); eng_valid = 1'b1; eng_rdata = d;
    sb_q.push_back({a, d});
    while (!eng_ready) @(negedge clk);
    @(negedge clk); eng_valid = 1'b0;
    #1 h = evt_half; dn = evt_done;
  endtask

  task automatic tx_byte(input logic [15:0] a, output logic dn);
    @(negedge clk); eng_valid = 1'b1;
    while (!eng_ready) @(negedge clk);
    #1;
    chk("R6 tx data", {24'h0, eng_tdata}, {24'h0, a[7:0] ^ 8'hA5});
    chk("R6 tx addr", {16'h0, mem_addr}, {16'h0, a});
    chk("R6 tx rd", {31'h0, mem_rd}, 32'h1);
    @(negedge clk); eng_valid = 1'b0;
    #1 dn = evt_done;
  endtask

  initial begin
    logic [31:0] v;
    logic h, dn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rreg(6'(i * 4), v); chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 ready", {31'h0, eng_ready}, 32'h0);
    chk("R1 events", {29'h0, evt_half, evt_done, evt_err}, 32'h0);

    // R2 map and read-only remain
    wreg(6'h00, 32'h1); wreg(6'h08, 32'h1000); wreg(6'h0C, 32'h0);
    rreg(6'h08, v); chk("R2 base", v, 32'h1000);
    rreg(6'h00, v); chk("R2 tctl", v, 32'h1);
    wreg(6'h10, 32'h55); rreg(6'h10, v); chk("R2 remain read-only", v, 32'h0);

    // R3 zero count does not arm
    wreg(6'h04, 32'h1); rreg(6'h04, v); chk("R3 zero count arm", v, 32'h0);
    pulse_ext(); #1 chk("R3 trigger unarmed", {31'h0, busy}, 32'h0);

    // R3 arm with count 4
    wreg(6'h0C, 32'h4); wreg(6'h04, 32'h1);
    rreg(6'h04, v); chk("R3 armed", v, 32'h1);
    rreg(6'h10, v); chk("R3 remain loaded", v, 32'h4);

    // R4 soft start, full receive run
    wreg(6'h00, 32'h8000_0001); #1 chk("R4 soft start", {31'h0, busy}, 32'h1);
    rx_byte(16'h1000, 8'h11, h, dn); chk("R8 no half at 1", {31'h0, h}, 32'h0);
    rx_byte(16'h1001, 8'h22, h, dn); chk("R8 half at 2", {31'h0, h}, 32'h1);
    rreg(6'h10, v); chk("R7 remain 2", v, 32'h2);
    rx_byte(16'h1002, 8'h33, h, dn); chk("R9 not done at 3", {31'h0, dn}, 32'h0);
    rx_byte(16'h1003, 8'h44, h, dn); chk("R9 done at 4", {31'h0, dn}, 32'h1);
    #1 chk("R9 idle", {31'h0, busy}, 32'h0);
    rreg(6'h04, v); chk("R9 disarmed", v, 32'h0);

    // R4 edge only, and stop by clearing
    wreg(6'h04, 32'h1);
    wreg(6'h00, 32'h8000_0001); #1 chk("R4 no start without edge", {31'h0, busy}, 32'h0);
    wreg(6'h00, 32'h1); wreg(6'h00, 32'h8000_0001);
    #1 chk("R4 start on edge", {31'h0, busy}, 32'h1);
    wreg(6'h00, 32'h1); #1 chk("R4 stop on clear", {31'h0, busy}, 32'h0);

    // R5 / R10 reload run with external trigger
    wreg(6'h0C, 32'h6); wreg(6'h04, 32'h3);
    rreg(6'h04, v); chk("R10 armed reload", v, 32'h3);
    pulse_ext(); #1 chk("R5 ext start", {31'h0, busy}, 32'h1);
    rx_byte(16'h1000, 8'h31, h, dn);
    pulse_ext(); rreg(6'h10, v); chk("R5 ext ignored while running", v, 32'h5);
    rx_byte(16'h1001, 8'h32, h, dn);
    rx_byte(16'h1002, 8'h33, h, dn); chk("R8 half at 3 of 6", {31'h0, h}, 32'h1);
    rx_byte(16'h1003, 8'h34, h, dn);
    rx_byte(16'h1004, 8'h35, h, dn);
    rx_byte(16'h1005, 8'h36, h, dn); chk("R10 done event", {31'h0, dn}, 32'h1);
    #1 chk("R10 idle after wrap", {31'h0, busy}, 32'h0);
    rreg(6'h04, v); chk("R10 stays armed", v, 32'h3);
    rreg(6'h10, v); chk("R10 remain rewound", v, 32'h6);
    pulse_ext(); #1 chk("R10 retrigger", {31'h0, busy}, 32'h1);
    rx_byte(16'h1000, 8'h41, h, dn);

    // R11 fault
    @(negedge clk); eng_fault = 1'b1;
    #1 chk("R11 ready low on fault", {31'h0, eng_ready}, 32'h0);
    @(negedge clk); eng_fault = 1'b0;
    #1 chk("R11 err event", {31'h0, evt_err}, 32'h1);
    chk("R11 stopped", {31'h0, busy}, 32'h0);
    rreg(6'h10, v); chk("R11 remain kept", v, 32'h5);

    // R6 transmit direction
    wreg(6'h04, 32'h0); wreg(6'h00, 32'h0); wreg(6'h08, 32'h2000);
    wreg(6'h0C, 32'h2); wreg(6'h04, 32'h1); wreg(6'h00, 32'h8000_0000);
    #1 chk("R6 tx start", {31'h0, busy}, 32'h1);
    tx_byte(16'h2000, dn);
    tx_byte(16'h2001, dn); chk("R9 tx done", {31'h0, dn}, 32'h1);

    repeat (2) @(negedge clk);
    chk("R6 scoreboard drained", sb_q.size(), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule